// File: doc/BRIEF.md
# Two's Complement Adder-Subtractor with Signed Compare

This block is a purely combinational arithmetic unit for signed integers held in two's complement form. It has two operands of parameterised width (four bits by default) and a mode select. It produces either the sum or the difference of the operands. It also reports the carry leaving the top bit, a signed overflow indication, the sign and zero state of the result, and three relational outputs derived from that result.

Subtraction uses the same adder as addition. The second operand is inverted bit by bit through a per-bit selector, and a one is injected as the initial carry. The adder is a ripple chain of full-adder cells. Overflow is judged by comparing the carry that enters the top cell with the carry that leaves it. To compare two values, drive subtract mode. The relational outputs then give a signed ordering of the operands whenever the difference did not overflow.

Operand range is -2^(WIDTH-1) to 2^(WIDTH-1)-1, and zero has exactly one encoding.

Top module: `addsub_cmp_unit`

## Requirements
- R1: With `sub_mode`=0, `result` equals (`opa` + `opb`) mod 2^WIDTH. With `sub_mode`=1, `result` equals (`opa` - `opb`) mod 2^WIDTH, formed as `opa` + inverted `opb` + 1.
- R2: `carry_out` is the carry leaving the top adder cell. In add mode it is 1 exactly when the unsigned sum exceeds 2^WIDTH-1. In subtract mode it is 1 exactly when `opa` >= `opb` as unsigned numbers.
- R3: `ovf` is 1 exactly when the true signed sum or difference lies outside -2^(WIDTH-1) .. 2^(WIDTH-1)-1. This is the case where the carry into the top cell differs from the carry out of it.
- R4: `neg` equals the most significant bit of `result`.
- R5: `zero` is 1 exactly when every bit of `result` is 0.
- R6: In both modes, `lt` equals `neg`, `eq` equals `zero`, and `le` equals `zero` OR `neg`.
- R7: In subtract mode, `eq` is 1 exactly when `opa` equals `opb`. When `ovf` is 0, `lt` and `le` give the signed relations `opa` < `opb` and `opa` <= `opb`. When `ovf` is 1, `lt` and `le` carry no ordering meaning.
- R8: With WIDTH=4, adding 0101 and 0011 yields 1000 with `ovf`=1. Subtracting 0010 from 1001 yields 0111 with `ovf`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First signed operand |
| opb | input | WIDTH | Second signed operand |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract (opa - opb) |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carry_out | output | 1 | Carry out of the most significant cell |
| ovf | output | 1 | Signed overflow |
| neg | output | 1 | Sign bit of result |
| zero | output | 1 | Result is all zeros |
| lt | output | 1 | Less-than, taken from the sign of the result |
| eq | output | 1 | Equal, taken from the zero state of the result |
| le | output | 1 | Less-or-equal, zero OR negative |

## Verification
The assertions watch four things continuously, whatever the inputs: the adder output against plain modular arithmetic, the top carry against a widened unsigned sum, the overflow flag against the operand and result signs, and equality and non-overflowing ordering in subtract mode. Other facts only show up through the bench's scenarios. These include the sweep of every operand pair in both modes, the two overflow cases of R8, the quiet state with all inputs zero, and the fact that `lt` and `le` lose their ordering meaning once a difference overflows.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } op_mode_e;

  // Sum output of one full-adder cell
  function automatic logic fa_sum(input logic a, input logic b, input logic ci);
    return a ^ b ^ ci;
  endfunction

  // Carry output of one full-adder cell: generate, or incoming carry passed on
  function automatic logic fa_carry(input logic a, input logic b, input logic ci);
    return (a & b) | (ci & (a | b));
  endfunction

  // Per-bit operand selector: true or complemented value
  function automatic logic pick_bit(input logic b, input logic invert);
    return invert ? ~b : b;
  endfunction

  // Initial carry injected for a given mode
  function automatic logic seed_carry(input op_mode_e mode);
    return (mode == MODE_SUB);
  endfunction

endpackage

// File: rtl/as_fa_cell.sv
module as_fa_cell
  import addsub_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  always_comb begin
    s_o = fa_sum(a_i, b_i, c_i);
    c_o = fa_carry(a_i, b_i, c_i);
  end
endmodule

// File: rtl/as_operand_mux.sv
module as_operand_mux
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] b_i,
  input  logic             invert_i,
  output logic [WIDTH-1:0] b_o
);
  for (genvar k = 0; k < WIDTH; k++) begin : g_sel
    always_comb b_o[k] = pick_bit(b_i[k], invert_i);
  end
endmodule

// File: rtl/as_ripple_chain.sv
module as_ripple_chain #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic [WIDTH:0]   carry_o
);
  assign carry_o[0] = cin_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_cell
    as_fa_cell u_cell (
      .a_i (a_i[k]),
      .b_i (b_i[k]),
      .c_i (carry_o[k]),
      .s_o (sum_o[k]),
      .c_o (carry_o[k+1])
    );
  end
endmodule

// File: rtl/as_flag_unit.sv
module as_flag_unit #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] sum_i,
  input  logic             sign_cin_i,
  input  logic             sign_cout_i,
  output logic             ovf_o,
  output logic             neg_o,
  output logic             zero_o,
  output logic             lt_o,
  output logic             eq_o,
  output logic             le_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    ovf_o  = sign_cin_i ^ sign_cout_i;
    neg_o  = sum_i[MSB];
    zero_o = ~(|sum_i);
    lt_o   = neg_o;
    eq_o   = zero_o;
    le_o   = zero_o | neg_o;
  end
endmodule

// File: rtl/addsub_cmp_unit.sv
module addsub_cmp_unit
  import addsub_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             sub_mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             ovf,
  output logic             neg,
  output logic             zero,
  output logic             lt,
  output logic             eq,
  output logic             le
);
  localparam int MSB = WIDTH - 1;

  op_mode_e         mode;
  logic             seed;
  logic [WIDTH-1:0] b_cond;
  logic [WIDTH:0]   chain;
  logic             sign_cin;
  logic             sign_cout;

  assign mode = op_mode_e'(sub_mode);
  assign seed = seed_carry(mode);

  as_operand_mux #(.WIDTH(WIDTH)) u_mux (
    .b_i      (opb),
    .invert_i (seed),
    .b_o      (b_cond)
  );

  as_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a_i     (opa),
    .b_i     (b_cond),
    .cin_i   (seed),
    .sum_o   (result),
    .carry_o (chain)
  );

  assign sign_cin  = chain[MSB];
  assign sign_cout = chain[WIDTH];
  assign carry_out = sign_cout;

  as_flag_unit #(.WIDTH(WIDTH)) u_flags (
    .sum_i       (result),
    .sign_cin_i  (sign_cin),
    .sign_cout_i (sign_cout),
    .ovf_o       (ovf),
    .neg_o       (neg),
    .zero_o      (zero),
    .lt_o        (lt),
    .eq_o        (eq),
    .le_o        (le)
  );
endmodule

// File: rtl/addsub_cmp_chk.sv
module addsub_cmp_chk #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             sub_mode,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             ovf,
  input logic             lt,
  input logic             eq
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] arith;
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH:0]   wide;

  always_comb begin
    arith = sub_mode ? (opa - opb) : (opa + opb);
    b_eff = sub_mode ? ~opb : opb;
    wide  = {1'b0, opa} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub_mode};
    AST_MOD_RESULT: assert (result == arith) else $error("result mismatch"); // R1
    AST_TOP_CARRY: assert (carry_out == wide[WIDTH]) else $error("carry mismatch"); // R2
    AST_SIGNED_OVF: assert (ovf == ((opa[MSB] == b_eff[MSB]) && (result[MSB] != opa[MSB]))) else $error("ovf mismatch"); // R3
    if (sub_mode) begin
      AST_SUB_EQUAL: assert (eq == (opa == opb)) else $error("eq mismatch"); // R7
    end
    if (sub_mode && !ovf) begin
      AST_SUB_ORDER: assert (lt == ($signed(opa) < $signed(opb))) else $error("lt mismatch"); // R7
    end
  end
endmodule

bind addsub_cmp_unit addsub_cmp_chk #(.WIDTH(WIDTH)) u_chk (
  .opa       (opa),
  .opb       (opb),
  .sub_mode  (sub_mode),
  .result    (result),
  .carry_out (carry_out),
  .ovf       (ovf),
  .lt        (lt),
  .eq        (eq)
);

// File: tb/sim_addsub_cmp_unit.sv
`timescale 1ns/1ps
module sim_addsub_cmp_unit;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic         sub_mode = 1'b0;
  logic [W-1:0] result;
  logic         carry_out, ovf, neg, zero, lt, eq, le;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int q_a[$];
  int q_b[$];
  int q_m[$];

  always #5 clk = ~clk;

  addsub_cmp_unit #(.WIDTH(W)) u0 (
    .opa(opa), .opb(opb), .sub_mode(sub_mode),
    .result(result), .carry_out(carry_out), .ovf(ovf),
    .neg(neg), .zero(zero), .lt(lt), .eq(eq), .le(le)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int to_signed(input int v);
    return (v >= HALF) ? v - (1 << W) : v;
  endfunction

  // Reference comparison on the falling edge, one vector per clock
  always @(negedge clk) begin
    if (!rst && q_a.size() > 0) begin
      int a, b, m, sa, sb, full, e_res, e_ovf, e_cry, e_neg, e_zero;
      a = q_a.pop_front(); b = q_b.pop_front(); m = q_m.pop_front();
      sa = to_signed(a); sb = to_signed(b);
      full   = m ? sa - sb : sa + sb;
      e_res  = full & MASK;
      e_ovf  = (full > HALF - 1 || full < -HALF) ? 1 : 0;
      e_cry  = m ? ((a >= b) ? 1 : 0) : ((a + b > MASK) ? 1 : 0);
      e_neg  = (e_res >= HALF) ? 1 : 0;
      e_zero = (e_res == 0) ? 1 : 0;
      chk("R1 result", int'(result), e_res);
      chk("R2 carry_out", int'(carry_out), e_cry);
      chk("R3 ovf", int'(ovf), e_ovf);
      chk("R4 neg", int'(neg), e_neg);
      chk("R5 zero", int'(zero), e_zero);
      chk("R6 lt", int'(lt), e_neg);
      chk("R6 eq", int'(eq), e_zero);
      chk("R6 le", int'(le), e_neg | e_zero);
      if (m == 1) begin
        chk("R7 eq", int'(eq), (a == b) ? 1 : 0);
        if (e_ovf == 0) begin
          chk("R7 lt", int'(lt), (sa < sb) ? 1 : 0);
          chk("R7 le", int'(le), (sa <= sb) ? 1 : 0);
        end
      end
      if (m == 0 && a == 5 && b == 3) begin
        chk("R8 add result", int'(result), 8);
        chk("R8 add ovf", int'(ovf), 1);
      end
      if (m == 1 && a == 9 && b == 2) begin
        chk("R8 sub result", int'(result), 7);
        chk("R8 sub ovf", int'(ovf), 1);
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // quiet state: all inputs zero (R5, R6)
    chk("R5 reset zero", int'(zero), 1);
    chk("R6 reset eq", int'(eq), 1);
    chk("R6 reset lt", int'(lt), 0);
    chk("R1 reset result", int'(result), 0);
    rst = 1'b0;
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a <= MASK; a++) begin
        for (int b = 0; b <= MASK; b++) begin
          @(posedge clk);
          opa <= W'(a); opb <= W'(b); sub_mode <= m[0];
          q_a.push_back(a); q_b.push_back(b); q_m.push_back(m);
        end
      end
    end
    repeat (3) @(posedge clk);
    chk("R1 queue drained", q_a.size(), 0);
    finish_run();
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end
endmodule